// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire slave serial port: a bit clock, a frame clock that marks which channel is active, and a serial data line. All three lines come from an external master and are asynchronous to the system clock. Each line passes through a synchronizer. The block then finds the rising edges of the bit clock in the system clock domain. On each of those edges it samples the data line and the frame-clock level. From these samples it builds each channel's word, most significant bit first.

A static select input chooses the framing. The first framing has the MSB one bit-clock late with left on the low frame-clock half. The second has the MSB right at the frame-clock change with left on the high half. Slots may be longer than the word, and any word up to 24 bits can be received. Short words come out left-aligned and zero-filled, so the sign stays in the top bit. A finished left/right pair appears on two parallel buses with a single-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and right after it is released, `pair_valid` is 0 and both output buses are all zeros.
- R2: With `fmt_lj` = 0, the channel is left while `fsync_in` is low and right while it is high. The MSB of a slot is the bit sampled on the second bit-clock rise after the frame clock changes. The bit sampled on the first rise after a change still belongs to the previous slot.
- R3: With `fmt_lj` = 1, the channel is left while `fsync_in` is high and right while it is low. The MSB is the bit sampled on the first bit-clock rise after the frame clock changes.
- R4: Data and frame-clock level are sampled only on rising edges of the bit clock. `pair_valid` can only rise in the cycle after a detected bit-clock rise.
- R5: Samples are two's complement and sent MSB first. A word of N < 24 bits appears in bits [23:24-N] of its output bus, and the low 24-N bits are 0.
- R6: Bits past the 24th bit of a slot have no effect on the output word.
- R7: A pair is presented when the right slot ends, which is at the next frame-clock change. At that point both buses update together and `pair_valid` is high for exactly one clock. Between strobes both buses hold their values.
- R8: After reset, bits before the first frame-clock change are ignored. A right word with no left word captured before it since the last pair is dropped and produces no strobe.
- R9: Each serial input passes through a 2-flop synchronizer. `pair_valid` is high after the third system-clock edge that follows the bit-clock rise ending the right slot, and it is low after the second such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| bclk_in | input | 1 | Serial bit clock from the master |
| fsync_in | input | 1 | Frame (channel) clock from the master |
| sdata_in | input | 1 | Serial data, two's complement, MSB first |
| left_word | output | 24 | Left sample, left-aligned |
| right_word | output | 24 | Right sample, left-aligned |
| pair_valid | output | 1 | One-cycle strobe when a new pair is on the buses |

## Verification
A pair becomes due at the bit-clock rise where the frame clock leaves the right slot. The strobe follows three system-clock edges later: two synchronizer flops, then the capture register. The bench drives each rise on a falling system-clock edge. It then confirms that the strobe is still low at the second falling edge after that and high at the third. A scoreboard monitor samples on every falling edge and compares each strobed pair with the next queued expectation. A strobe with no expectation queued counts as a miscompare, and so do expectations still left when a segment ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } fmt_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_edge.sv
module sar_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_lj,
    input  logic              bit_rise,
    input  logic              fs_lvl,
    input  logic              data_bit,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              pair_valid
);
    localparam int unsigned CW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              seen;
        logic              fs_prev;
        logic              active;
        chan_e             chan;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] sh;
        logic              left_ok;
        logic [WORD_W-1:0] left_hold;
        logic [WORD_W-1:0] out_l;
        logic [WORD_W-1:0] out_r;
        logic              vld;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [WORD_W-1:0] with_bit;
    logic [WORD_W-1:0] finished;
    logic              lj_mode;
    logic              boundary;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        lj_mode  = (fmt_e'(fmt_lj) == FMT_LJ);
        boundary = 1'b0;

        with_bit = st_q.sh;
        for (int i = 0; i < WORD_W; i++) begin
            if (st_q.cnt == CW'(i)) with_bit[WORD_W-1-i] = data_bit;
        end
        finished = lj_mode ? st_q.sh : with_bit;

        if (bit_rise) begin
            st_d.fs_prev = fs_lvl;
            if (!st_q.seen) begin
                st_d.seen = 1'b1;
            end else begin
                boundary = (fs_lvl != st_q.fs_prev);
                if (boundary) begin
                    if (st_q.active) begin
                        if (st_q.chan == CH_LEFT) begin
                            st_d.left_hold = finished;
                            st_d.left_ok   = 1'b1;
                        end else begin
                            if (st_q.left_ok) begin
                                st_d.out_l = st_q.left_hold;
                                st_d.out_r = finished;
                                st_d.vld   = 1'b1;
                            end
                            st_d.left_ok = 1'b0;
                        end
                    end
                    st_d.active = 1'b1;
                    st_d.sh     = '0;
                    if (lj_mode) begin
                        st_d.chan         = fs_lvl ? CH_LEFT : CH_RIGHT;
                        st_d.sh[WORD_W-1] = data_bit;
                        st_d.cnt          = CW'(1);
                    end else begin
                        st_d.chan = fs_lvl ? CH_RIGHT : CH_LEFT;
                        st_d.cnt  = '0;
                    end
                end else if (st_q.active && (st_q.cnt < CW'(WORD_W))) begin
                    st_d.sh  = with_bit;
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_word  = st_q.out_l;
    assign right_word = st_q.out_r;
    assign pair_valid = st_q.vld;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int unsigned WORD_W      = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_lj,
    input  logic              bclk_in,
    input  logic              fsync_in,
    input  logic              sdata_in,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              pair_valid
);
    localparam int unsigned NLINES = 3;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] synced;
    logic              bclk_rise;

    assign raw_lines = {bclk_in, fsync_in, sdata_in};

    sar_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (synced)
    );

    sar_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (synced[2]),
        .rise (bclk_rise)
    );

    sar_core #(.WORD_W(WORD_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_lj    (fmt_lj),
        .bit_rise  (bclk_rise),
        .fs_lvl    (synced[1]),
        .data_bit  (synced[0]),
        .left_word (left_word),
        .right_word(right_word),
        .pair_valid(pair_valid)
    );
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
    parameter int unsigned WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bclk_in,
    input logic              bclk_rise,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word,
    input logic              pair_valid
);
    assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(left_word) && $stable(right_word)));

    assert_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(bclk_rise));

    assert_sync_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_rise |-> $past(bclk_in, 2));
endmodule

bind serial_audio_rx sar_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .bclk_rise (bclk_rise),
    .left_word (left_word),
    .right_word(right_word),
    .pair_valid(pair_valid)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_lj = 1'b0;
    logic        bclk_in = 1'b0;
    logic        fsync_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [23:0] left_word, right_word;
    logic        pair_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit pending  = 1'b0;
    logic tail   = 1'b0;
    logic [47:0] exp_q[$];

    always #2 clk = ~clk;

    serial_audio_rx uut (
        .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj),
        .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
        .left_word(left_word), .right_word(right_word), .pair_valid(pair_valid)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected pair", {left_word, right_word}, 48'h0);
                if ({left_word, right_word} == 48'h0) begin
                    n_fail++;
                    $display("FAIL R8 strobe with empty queue actual=1 expected=0");
                end
            end else begin
                check("R5/R7 pair", {left_word, right_word}, exp_q.pop_front());
            end
        end
    end

    function automatic logic bitof(input logic [23:0] w, input int wlen, input int k, input logic pad);
        if (k < wlen) return w[wlen-1-k];
        return pad;
    endfunction

    task automatic bit_cycle(input logic fs, input logic d, input bit chk);
        @(negedge clk);
        bclk_in = 1'b0; fsync_in = fs; sdata_in = d;
        repeat (3) @(negedge clk);
        bclk_in = 1'b1;
        if (chk) begin
            repeat (2) @(negedge clk);
            check("R9 strobe not before third edge", {47'h0, pair_valid}, 48'h0);
            @(negedge clk);
            check("R9 strobe at third edge", {47'h0, pair_valid}, 48'h1);
            @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic send_slot(input logic lvl, input int slot, input int wlen,
                             input logic [23:0] w, input logic pad);
        for (int i = 0; i < slot; i++) begin
            logic d;
            if (fmt_lj) d = bitof(w, wlen, i, pad);
            else        d = (i == 0) ? tail : bitof(w, wlen, i - 1, pad);
            bit_cycle(lvl, d, (i == 0) && pending);
            if (i == 0) pending = 1'b0;
        end
        tail = fmt_lj ? 1'b0 : bitof(w, wlen, slot - 1, pad);
    endtask

    task automatic send_frame(input int wlen, input int slot, input logic [23:0] l,
                              input logic [23:0] r, input logic pad);
        logic lv;
        logic [23:0] el, er;
        lv = fmt_lj ? 1'b1 : 1'b0;
        el = l << (24 - wlen);
        er = r << (24 - wlen);
        send_slot(lv, slot, wlen, l, pad);
        send_slot(~lv, slot, wlen, r, pad);
        exp_q.push_back({el, er});
        pending = 1'b1;
    endtask

    task automatic flush_and_drain();
        send_slot(fmt_lj ? 1'b1 : 1'b0, 2, 0, 24'h0, 1'b0);
        repeat (10) @(negedge clk);
        check("R8 queue drained", 48'(exp_q.size()), 48'h0);
        exp_q.delete();
    endtask

    task automatic do_reset(input logic fmt);
        @(negedge clk);
        rst_n = 1'b0; bclk_in = 1'b0; fsync_in = 1'b0; sdata_in = 1'b0;
        fmt_lj = fmt; pending = 1'b0; tail = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 reset outputs", {left_word, right_word}, 48'h0);
        check("R1 reset strobe", {47'h0, pair_valid}, 48'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {left_word, right_word, 1'b0} >> 1, 48'h0);
    endtask

    initial begin
        // I2S segment: R2, R5, R6, R8
        do_reset(1'b0);
        bit_cycle(1'b1, 1'b1, 1'b0);     // stray bits before first boundary (R8)
        bit_cycle(1'b1, 1'b0, 1'b0);
        bit_cycle(1'b1, 1'b1, 1'b0);
        send_frame(24, 32, 24'h123456, 24'hFEDCBA, 1'b0);   // R2
        send_frame(24, 32, 24'h800000, 24'h7FFFFF, 1'b1);   // R6 trailing ones ignored
        send_frame(16, 16, 24'h008001, 24'h007FFE, 1'b0);   // R5 short word, full slot
        send_frame(20, 32, 24'h0ABCDE, 24'h0F0F0F, 1'b0);   // R5
        flush_and_drain();

        // left-justified segment: R3, R5, R6, R8
        do_reset(1'b1);
        bit_cycle(1'b1, 1'b1, 1'b0);
        bit_cycle(1'b1, 1'b0, 1'b0);
        send_slot(1'b0, 32, 24, 24'hAAAAAA, 1'b0);          // R8 orphan right slot
        send_frame(24, 32, 24'h654321, 24'h9ABCDE, 1'b0);   // R3
        send_frame(18, 32, 24'h020001, 24'h01FFFF, 1'b0);   // R5
        send_frame(24, 32, 24'hC00003, 24'h3FFFFC, 1'b1);   // R6
        send_frame(12, 32, 24'h000800, 24'h0007FF, 1'b0);   // R5
        flush_and_drain();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule